// File: doc/BRIEF.md
# Key-Armed Watchdog Timer

This block is a watchdog built on a 64-bit up-counter. A simple register write port lets software choose the timer mode, preload the counter and the 64-bit limit, and write keys into a control register. The watchdog is armed only through a fixed two-step key handshake, and only while the mode field selects watchdog operation. Arming goes from idle, through a pre-armed step, to running.

While running, the counter advances on every clock. Software keeps the system alive with the same two-key pair, which restarts the count from zero. A control write that carries any unexpected key while running raises the reset request at once. So does the counter reaching the programmed limit. The reset request is a registered, sticky level. It stays high, and the whole block stays frozen, until the block's own `rst_n` is asserted.

The write port is a plain strobe with select and data. It carries no back-pressure, and every strobe takes effect on the rising clock edge where `wr_en` is high. Select codes: 0 = mode, 1 = count low word, 2 = count high word, 3 = limit low word, 4 = limit high word, 5 = watchdog control.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, `wdt_rst_o` is 0, `wd_state_o` is 0 (idle) and `wd_count_o` is 0. The limit resets to all ones, and the mode field resets to 0.
- R2: The mode register (select 0) holds a 2-bit field in data bits 3:2. Only the value 2 enables watchdog operation. With any other value, both arming keys leave the state unchanged.
- R3: In idle (state 0), a control write (select 5) moves the state to pre-armed (1) only when data bits 31:16 equal 0xA5C6, data bit 14 is 1 and the mode is 2. Any other control write leaves the state at 0 and does not raise `wdt_rst_o`.
- R4: In pre-armed (state 1), a control write moves the state to running (2) only when bits 31:16 equal 0xDA7E, bit 14 is 1 and the mode is 2. Any other control write leaves the state at 1 and does not raise `wdt_rst_o`.
- R5: In states 2 and 3 the count rises by 1 on every clock. In states 0 and 1 the count holds, and writes to select 1 or 2 load its low or high 32-bit word.
- R6: In state 2, a control write with key 0xA5C6 moves the state to 3 (service pending). In state 3, a control write with key 0xDA7E returns the state to 2, and the count reads 0 after that edge.
- R7: In state 2, a control write whose key is not 0xA5C6 raises `wdt_rst_o` on the next edge. In state 3, a key other than 0xDA7E does the same.
- R8: In states 2 and 3, when the count equals the 64-bit limit (low word at select 3, high word at select 4), the count holds and `wdt_rst_o` rises on the next edge. A limit of 0 makes the watchdog fire one clock after it starts running.
- R9: In states 2 and 3, writes to the mode, count and limit registers are ignored, and no write returns the state to 0 or 1.
- R10: Once `wdt_rst_o` is high, it stays high. The state and count then stay frozen, and every write is ignored until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 mode, 1/2 count words, 3/4 limit words, 5 control) |
| wr_data | input | 32 | Write data |
| wdt_rst_o | output | 1 | Sticky reset request |
| wd_state_o | output | 2 | Key state: 0 idle, 1 pre-armed, 2 running, 3 service pending |
| wd_count_o | output | 64 | Current 64-bit count |

## Verification
The bound checker checks the following on every cycle:
- the reset request stays high once raised, and the state and count freeze with it;
- the state never leaves the running states and never jumps out of idle to anything but pre-armed;
- any bad key in the running state leads to a reset one edge later;
- the count steps by one while running and holds while idle;
- a completed service key pair clears the count.

Only the bench's scenarios can show the end-to-end effects:
- preloaded limits and counts giving exactly the right expiry cycle;
- writes that are ignored while running, and wrong keys that are harmless while arming;
- the mode gate on arming;
- the zero-limit and service-pending corner cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_PRE  = 2'd1,
    WD_RUN  = 2'd2,
    WD_SVC  = 2'd3
  } wd_state_e;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam int          KEY_LSB    = 16;
  localparam int          EN_BIT     = 14;
  localparam int          MODE_LSB   = 2;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;

  localparam int SEL_MODE     = 0;
  localparam int SEL_CNT_BASE = 1;
  localparam int SEL_PER_BASE = 3;
  localparam int SEL_CTL      = 5;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  output logic              mode_wd,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W/DATA_W-1:0] cnt_seg_we
);
  localparam int NSEG = CNT_W / DATA_W;

  logic [1:0] mode_q;
  logic       open_wr;

  assign open_wr = wr_en & ~lock;
  assign mode_wd = (mode_q == MODE_WDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (open_wr && wr_sel == SEL_W'(SEL_MODE)) begin
      mode_q <= wr_data[MODE_LSB +: 2];
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [DATA_W-1:0] per_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q <= '1;
      end else if (open_wr && wr_sel == SEL_W'(SEL_PER_BASE + s)) begin
        per_q <= wr_data;
      end
    end

    assign period[s*DATA_W +: DATA_W] = per_q;
    assign cnt_seg_we[s] = open_wr && (wr_sel == SEL_W'(SEL_CNT_BASE + s));
  end
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              mode_wd,
  input  logic              expire,
  output wd_state_e         state,
  output logic              bite,
  output logic              svc_clr
);
  wd_state_e  nxt;
  logic       bad_key;
  logic [15:0] key;
  logic       en;

  assign key = ctl_data[KEY_LSB +: 16];
  assign en  = ctl_data[EN_BIT];

  always_comb begin
    nxt     = state;
    bad_key = 1'b0;
    svc_clr = 1'b0;
    if (ctl_we) begin
      unique case (state)
        WD_IDLE: if (key == KEY_FIRST && en && mode_wd) nxt = WD_PRE;
        WD_PRE:  if (key == KEY_SECOND && en && mode_wd) nxt = WD_RUN;
        WD_RUN: begin
          if (key == KEY_FIRST) nxt = WD_SVC;
          else                  bad_key = 1'b1;
        end
        WD_SVC: begin
          if (key == KEY_SECOND) begin
            nxt     = WD_RUN;
            svc_clr = 1'b1;
          end else begin
            bad_key = 1'b1;
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WD_IDLE;
      bite  <= 1'b0;
    end else begin
      state <= nxt;
      bite  <= bite | bad_key | expire;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    clr,
  input  logic [CNT_W/DATA_W-1:0] seg_we,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [CNT_W-1:0]        period,
  output logic [CNT_W-1:0]        count,
  output logic                    at_period
);
  localparam int NSEG = CNT_W / DATA_W;

  logic [CNT_W-1:0] count_d;

  assign at_period = (count == period);

  always_comb begin
    count_d = count;
    if (clr) begin
      count_d = '0;
    end else if (run) begin
      if (!at_period) count_d = count + CNT_W'(1);
    end else begin
      for (int s = 0; s < NSEG; s++) begin
        if (seg_we[s]) count_d[s*DATA_W +: DATA_W] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_rst_o,
  output logic [1:0]        wd_state_o,
  output logic [CNT_W-1:0]  wd_count_o
);
  localparam int NSEG = CNT_W / DATA_W;

  wd_state_e        state;
  logic             bite;
  logic             svc_clr;
  logic             running;
  logic             run;
  logic             lock;
  logic             ctl_we;
  logic             mode_wd;
  logic             at_period;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] count;
  logic [NSEG-1:0]  cnt_seg_we;

  assign running = (state == WD_RUN) || (state == WD_SVC);
  assign run     = running & ~bite;
  assign lock    = running | bite;
  assign ctl_we  = wr_en && !bite && (wr_sel == SEL_W'(SEL_CTL));

  wdt_cfg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .lock       (lock),
    .mode_wd    (mode_wd),
    .period     (period),
    .cnt_seg_we (cnt_seg_we)
  );

  wdt_key_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_data (wr_data),
    .mode_wd  (mode_wd),
    .expire   (run & at_period),
    .state    (state),
    .bite     (bite),
    .svc_clr  (svc_clr)
  );

  wdt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clr       (svc_clr),
    .seg_we    (cnt_seg_we),
    .wr_data   (wr_data),
    .period    (period),
    .count     (count),
    .at_period (at_period)
  );

  assign wdt_rst_o  = bite;
  assign wd_state_o = state;
  assign wd_count_o = count;
endmodule

// File: rtl/wdt_keyed_checker.sv
module wdt_keyed_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              wdt_rst_o,
  input logic [1:0]        wd_state_o,
  input logic [CNT_W-1:0]  wd_count_o
);
  logic ctl_wr;
  logic cnt_wr;
  assign ctl_wr = wr_en && (wr_sel == SEL_W'(5));
  assign cnt_wr = wr_en && (wr_sel == SEL_W'(1) || wr_sel == SEL_W'(2));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> wdt_rst_o);

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> ($stable(wd_count_o) && $stable(wd_state_o)));

  p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_state_o == 2'd0) |=> (wd_state_o == 2'd0 || wd_state_o == 2'd1));

  p_no_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_state_o[1] |=> wd_state_o[1]);

  p_bad_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wd_state_o == 2'd2 && wr_data[31:16] != 16'hA5C6) |=> wdt_rst_o);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_state_o[1] && !wdt_rst_o && !ctl_wr)
      |=> ((wd_count_o == $past(wd_count_o) + CNT_W'(1)) || wdt_rst_o));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_state_o[1] && !cnt_wr) |=> $stable(wd_count_o));

  p_svc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wd_state_o == 2'd3 && wr_data[31:16] == 16'hDA7E && !wdt_rst_o)
      |=> (wd_count_o == '0));
endmodule

bind wdt_keyed_top wdt_keyed_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .wdt_rst_o  (wdt_rst_o),
  .wd_state_o (wd_state_o),
  .wd_count_o (wd_count_o)
);

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic        wdt_rst_o;
  logic [1:0]  wd_state_o;
  logic [63:0] wd_count_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic        m_rst;
  int          m_state;
  logic [63:0] m_count;
  logic [63:0] m_period;
  logic [1:0]  m_mode;

  always #10 clk = ~clk;

  wdt_keyed_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wdt_rst_o(wdt_rst_o), .wd_state_o(wd_state_o), .wd_count_o(wd_count_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = 0; m_state = 0; m_count = 0; m_period = '1; m_mode = 0;
    end else if (!m_rst) begin
      automatic logic [15:0] key = wr_data[31:16];
      automatic bit ctl = wr_en && wr_sel == 3'd5;
      automatic bit act = (m_state >= 2);
      automatic bit hit = act && (m_count == m_period);
      automatic bit bad = 0;
      automatic bit clr = 0;
      automatic int ns = m_state;
      if (ctl) begin
        if (m_state == 0 && key == 16'hA5C6 && wr_data[14] && m_mode == 2) ns = 1;
        else if (m_state == 1 && key == 16'hDA7E && wr_data[14] && m_mode == 2) ns = 2;
        else if (m_state == 2) begin
          if (key == 16'hA5C6) ns = 3; else bad = 1;
        end else if (m_state == 3) begin
          if (key == 16'hDA7E) begin ns = 2; clr = 1; end else bad = 1;
        end
      end
      if (clr) m_count = 0;
      else if (act) begin
        if (!hit) m_count = m_count + 64'd1;
      end else if (wr_en && wr_sel == 3'd1) m_count[31:0] = wr_data;
      else if (wr_en && wr_sel == 3'd2) m_count[63:32] = wr_data;
      if (!act && wr_en) begin
        if (wr_sel == 3'd0) m_mode = wr_data[3:2];
        if (wr_sel == 3'd3) m_period[31:0] = wr_data;
        if (wr_sel == 3'd4) m_period[63:32] = wr_data;
      end
      m_state = ns;
      m_rst = bad | hit;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (rst_n) begin
      chk(wdt_rst_o == m_rst, {cur_req, " rst"}, 64'(wdt_rst_o), 64'(m_rst));
      chk(int'(wd_state_o) == m_state, {cur_req, " state"}, 64'(wd_state_o), 64'(m_state));
      chk(wd_count_o == m_count, {cur_req, " count"}, wd_count_o, m_count);
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);
  endtask

  task automatic arm();
    wr(3'd0, 32'h8);
    wr(3'd5, 32'hA5C6_4000);
    wr(3'd5, 32'hDA7E_4000);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    cur_req = "R1";
    chk(wdt_rst_o == 0 && wd_state_o == 0 && wd_count_o == 0, "R1 reset state",
        {wd_count_o[61:0], wd_state_o}, 64'd0);

    cur_req = "R2";
    wr(3'd5, 32'hA5C6_4000);
    chk(wd_state_o == 2'd0, "R2 mode gate", 64'(wd_state_o), 64'd0);
    wr(3'd0, 32'h8);

    cur_req = "R3";
    wr(3'd5, 32'h1234_4000);
    chk(wd_state_o == 2'd0 && !wdt_rst_o, "R3 wrong key idle", 64'(wd_state_o), 64'd0);
    wr(3'd5, 32'hA5C6_0000);
    chk(wd_state_o == 2'd0, "R3 enable bit clear", 64'(wd_state_o), 64'd0);
    wr(3'd5, 32'hA5C6_4000);
    chk(wd_state_o == 2'd1, "R3 first key", 64'(wd_state_o), 64'd1);

    cur_req = "R4";
    wr(3'd5, 32'h0000_4000);
    chk(wd_state_o == 2'd1 && !wdt_rst_o, "R4 wrong key pre", 64'(wd_state_o), 64'd1);
    wr(3'd5, 32'hA5C6_4000);
    chk(wd_state_o == 2'd1, "R4 repeat first key", 64'(wd_state_o), 64'd1);

    cur_req = "R5";
    wr(3'd3, 32'd100);
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd0);
    chk(wd_count_o == 64'd5, "R5 count load", wd_count_o, 64'd5);
    idle(3);
    chk(wd_count_o == 64'd5, "R5 count holds", wd_count_o, 64'd5);

    cur_req = "R4";
    wr(3'd5, 32'hDA7E_4000);
    chk(wd_state_o == 2'd2 && wd_count_o == 64'd5, "R4 second key", 64'(wd_state_o), 64'd2);

    cur_req = "R5";
    idle(10);
    chk(wd_count_o == 64'd15, "R5 counting", wd_count_o, 64'd15);

    cur_req = "R9";
    wr(3'd3, 32'd3);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    chk(wd_count_o == 64'd18 && wd_state_o == 2'd2, "R9 writes locked", wd_count_o, 64'd18);
    idle(2);
    chk(!wdt_rst_o, "R9 limit unchanged", 64'(wdt_rst_o), 64'd0);

    cur_req = "R6";
    wr(3'd5, 32'hA5C6_0000);
    chk(wd_state_o == 2'd3, "R6 service pending", 64'(wd_state_o), 64'd3);
    wr(3'd5, 32'hDA7E_0000);
    chk(wd_state_o == 2'd2 && wd_count_o == 64'd0, "R6 service clears", wd_count_o, 64'd0);

    cur_req = "R8";
    idle(100);
    chk(wd_count_o == 64'd100 && !wdt_rst_o, "R8 at limit", wd_count_o, 64'd100);
    idle(1);
    chk(wdt_rst_o && wd_count_o == 64'd100, "R8 expiry", 64'(wdt_rst_o), 64'd1);

    cur_req = "R10";
    idle(5);
    wr(3'd5, 32'hA5C6_4000);
    wr(3'd1, 32'd7);
    chk(wdt_rst_o && wd_count_o == 64'd100 && wd_state_o == 2'd2, "R10 frozen",
        wd_count_o, 64'd100);

    cur_req = "R7";
    do_reset();
    arm();
    idle(2);
    wr(3'd5, 32'h0000_4000);
    chk(wdt_rst_o == 1'b1, "R7 bad key running", 64'(wdt_rst_o), 64'd1);

    cur_req = "R8";
    do_reset();
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd0);
    arm();
    chk(wd_state_o == 2'd2 && !wdt_rst_o, "R8 zero limit start", 64'(wd_state_o), 64'd2);
    idle(1);
    chk(wdt_rst_o == 1'b1, "R8 zero limit fires", 64'(wdt_rst_o), 64'd1);

    cur_req = "R7";
    do_reset();
    arm();
    wr(3'd5, 32'hA5C6_0000);
    chk(!wdt_rst_o && wd_state_o == 2'd3, "R7 pending ok", 64'(wd_state_o), 64'd3);
    wr(3'd5, 32'hA5C6_0000);
    chk(wdt_rst_o == 1'b1, "R7 bad key pending", 64'(wdt_rst_o), 64'd1);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule